// File: doc/BRIEF.md
# AXI4-Lite to Register Bridge with Clock Crossing

This block is a 32-bit AXI4-Lite slave in a CPU clock domain. It turns every bus transaction into a single access on a simple register port that runs in a separate user clock domain. The register port has one word address shared by reads and writes. A write is a single-cycle enable with data and a byte enable. A read is a single-cycle request, and the slave closes it by raising a read-valid strobe with the data, after as many cycles as it needs.

Each AXI channel group captures its own beat in a one-deep slot: write address, write data and read address. An arbiter in the CPU domain starts one register access at a time and gives writes precedence. The access is carried across the domain boundary with a toggle on a two-flop synchronizer. Its payload is held still while the toggle travels. Completion comes back on a second toggle, and only then does the bridge raise the AXI write response or the read data.

Top module: `axil_reg_bridge`

## Requirements
- R1: The AW, W and AR channels each accept a beat independently, into a one-deep slot. The ready of a channel is low while its slot holds a beat that has not yet been issued.
- R2: An accepted write produces exactly one user-clock cycle of `reg_wr_en`. In that cycle `reg_addr` equals AXI byte address bits [ADDR_W-1:2] (the word address) and `reg_wr_data` equals the W data.
- R3: An accepted read produces exactly one user-clock cycle of `reg_rd_req`, with `reg_addr` equal to the read word address. `reg_addr` stays unchanged until `reg_rd_valid` is seen, for any latency of one cycle or more.
- R4: `s_rdata` equals the `reg_rd_data` value presented with `reg_rd_valid`, and `s_rresp` is 2'b00 (OKAY).
- R5: `s_bvalid` rises only after the user-domain write has taken place and its acknowledge has crossed back. `s_bresp` is 2'b00 (OKAY).
- R6: Only one access is outstanding. No new register access starts until the previous access has been acknowledged and its AXI response has been handshaken.
- R7: When a complete write (address and data) and a read are both waiting while the bridge is idle, the write is issued first.
- R8: Once raised, `s_bvalid` stays high until `s_bready`. `s_rvalid` stays high with `s_rdata` unchanged until `s_rready`.
- R9: `reg_wr_be` equals the W strobe, and bit i qualifies data bits [8i+7:8i]. An all-zero strobe still produces the write pulse, with `reg_wr_be` = 4'b0000.
- R10: A write is not issued until both its address and its data beats have been accepted. An address beat alone produces no register write and no response.
- R11: After reset, all three channel readies are high, `s_bvalid` and `s_rvalid` are low, and `reg_wr_en` and `reg_rd_req` are low.
- R12: A `reg_rd_valid` pulse that arrives while no read is pending has no effect: no `s_rvalid` appears, and the data of the next read is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | CPU-domain clock |
| aresetn | input | 1 | CPU-domain reset, active low |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| uclk | input | 1 | User-domain clock |
| urst_n | input | 1 | User-domain reset, active low |
| reg_addr | output | ADDR_W-2 | Shared register word address |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 32 | Register write data |
| reg_wr_be | output | 4 | Register write byte enable |
| reg_rd_req | output | 1 | One-cycle register read request |
| reg_rd_data | input | 32 | Register read data |
| reg_rd_valid | input | 1 | Register read data valid |

## Verification
A lost or duplicated toggle shows at the ports within a few clocks of either domain. The bridge then hangs with no AXI response, or it emits a second write pulse, which the register-side model counts. If the shared address is corrupted, it is caught during the read latency window, because the model compares `reg_addr` on every user cycle until it returns valid. Wrong slot or arbitration state shows up on the next transaction as a write that fires without its data beat, a write issued after a waiting read, or returned data that does not match the byte-merged contents the bench predicts.

// File: rtl/axil_bridge_pkg.sv
package axil_bridge_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {F_IDLE, F_BUSY, F_BRESP, F_RRESP} front_st_t;
  typedef enum logic {U_IDLE, U_WAIT} back_st_t;

  // Edge of a toggle handshake: synced level differs from the level last seen.
  function automatic logic tog_edge(input logic synced, input logic seen);
    return synced ^ seen;
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/axil_front.sv
module axil_front
  import axil_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_STAGES = 2,
  localparam int RW = ADDR_W - 2
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              xfer_tog,
  output logic              xfer_wr,
  output logic [RW-1:0]     xfer_addr,
  output logic [DATA_W-1:0] xfer_wdata,
  output logic [STRB_W-1:0] xfer_be,
  input  logic              ack_tog_async,
  input  logic [DATA_W-1:0] rd_hold_async
);
  front_st_t         st;
  logic              aw_full, w_full, ar_full;
  logic [RW-1:0]     aw_word_q, ar_word_q;
  logic [DATA_W-1:0] w_data_q;
  logic [STRB_W-1:0] w_be_q;
  logic              ack_sync, ack_seen;

  // Named events for the assertions
  logic aw_take, w_take, ar_take;
  logic launch_wr, launch_rd, ack_edge;

  assign s_awready = !aw_full;
  assign s_wready  = !w_full;
  assign s_arready = !ar_full;
  assign aw_take   = s_awvalid && s_awready;
  assign w_take    = s_wvalid && s_wready;
  assign ar_take   = s_arvalid && s_arready;
  assign launch_wr = (st == F_IDLE) && aw_full && w_full;
  assign launch_rd = (st == F_IDLE) && !(aw_full && w_full) && ar_full;
  assign ack_edge  = tog_edge(ack_sync, ack_seen);

  bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(aclk), .rst_n(aresetn), .d(ack_tog_async), .q(ack_sync)
  );

  // Channel slots
  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn) begin
      aw_full <= 1'b0; w_full <= 1'b0; ar_full <= 1'b0;
      aw_word_q <= '0; ar_word_q <= '0; w_data_q <= '0; w_be_q <= '0;
    end else begin
      if (aw_take) begin
        aw_full   <= 1'b1;
        aw_word_q <= RW'(s_awaddr >> 2);
      end else if (launch_wr) begin
        aw_full <= 1'b0;
      end
      if (w_take) begin
        w_full   <= 1'b1;
        w_data_q <= s_wdata;
        w_be_q   <= s_wstrb;
      end else if (launch_wr) begin
        w_full <= 1'b0;
      end
      if (ar_take) begin
        ar_full   <= 1'b1;
        ar_word_q <= RW'(s_araddr >> 2);
      end else if (launch_rd) begin
        ar_full <= 1'b0;
      end
    end
  end

  // Transaction sequencer and crossing payload
  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn) begin
      st <= F_IDLE;
      xfer_tog <= 1'b0; xfer_wr <= 1'b0; xfer_addr <= '0;
      xfer_wdata <= '0; xfer_be <= '0;
      ack_seen <= 1'b0;
      s_rdata <= '0;
    end else begin
      unique case (st)
        F_IDLE: begin
          if (launch_wr) begin
            xfer_wr    <= 1'b1;
            xfer_addr  <= aw_word_q;
            xfer_wdata <= w_data_q;
            xfer_be    <= w_be_q;
            xfer_tog   <= ~xfer_tog;
            st         <= F_BUSY;
          end else if (launch_rd) begin
            xfer_wr   <= 1'b0;
            xfer_addr <= ar_word_q;
            xfer_tog  <= ~xfer_tog;
            st        <= F_BUSY;
          end
        end
        F_BUSY: begin
          if (ack_edge) begin
            ack_seen <= ack_sync;
            if (xfer_wr) begin
              st <= F_BRESP;
            end else begin
              s_rdata <= rd_hold_async;
              st      <= F_RRESP;
            end
          end
        end
        F_BRESP: if (s_bready) st <= F_IDLE;
        F_RRESP: if (s_rready) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  assign s_bvalid = (st == F_BRESP);
  assign s_rvalid = (st == F_RRESP);
  assign s_bresp  = RESP_OKAY;
  assign s_rresp  = RESP_OKAY;

  a_r8_bvalid_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid && !s_bready |=> s_bvalid);
  a_r8_rvalid_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  a_r5_b_after_ack: assert property (@(posedge aclk) disable iff (!aresetn)
    $rose(s_bvalid) |-> $past(ack_edge));
  a_r7_write_first: assert property (@(posedge aclk) disable iff (!aresetn)
    (st == F_IDLE) && aw_full && w_full && ar_full |=> xfer_wr && ar_full);
  a_r1_aw_slot_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    aw_full && !launch_wr |=> aw_full && $stable(aw_word_q));
  a_r6_one_launch: assert property (@(posedge aclk) disable iff (!aresetn)
    (st != F_IDLE) |-> !launch_wr && !launch_rd);
endmodule

// File: rtl/reg_back.sv
module reg_back
  import axil_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_STAGES = 2,
  localparam int RW = ADDR_W - 2
) (
  input  logic              uclk,
  input  logic              urst_n,
  input  logic              xfer_tog_async,
  input  logic              xfer_wr,
  input  logic [RW-1:0]     xfer_addr,
  input  logic [DATA_W-1:0] xfer_wdata,
  input  logic [STRB_W-1:0] xfer_be,
  output logic              ack_tog,
  output logic [DATA_W-1:0] rd_hold,
  output logic [RW-1:0]     reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic [STRB_W-1:0] reg_wr_be,
  output logic              reg_rd_req,
  input  logic [DATA_W-1:0] reg_rd_data,
  input  logic              reg_rd_valid
);
  back_st_t st;
  logic     req_sync, req_seen;
  logic     req_edge, rd_pending;

  bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(uclk), .rst_n(urst_n), .d(xfer_tog_async), .q(req_sync)
  );

  assign req_edge   = tog_edge(req_sync, req_seen);
  assign rd_pending = (st == U_WAIT);

  always_ff @(posedge uclk or negedge urst_n) begin
    if (!urst_n) begin
      st <= U_IDLE;
      req_seen <= 1'b0; ack_tog <= 1'b0; rd_hold <= '0;
      reg_addr <= '0; reg_wr_en <= 1'b0; reg_wr_data <= '0; reg_wr_be <= '0;
      reg_rd_req <= 1'b0;
    end else begin
      reg_wr_en  <= 1'b0;
      reg_rd_req <= 1'b0;
      unique case (st)
        U_IDLE: begin
          if (req_edge) begin
            req_seen <= req_sync;
            reg_addr <= xfer_addr;
            if (xfer_wr) begin
              reg_wr_en   <= 1'b1;
              reg_wr_data <= xfer_wdata;
              reg_wr_be   <= xfer_be;
              ack_tog     <= ~ack_tog;
            end else begin
              reg_rd_req <= 1'b1;
              st         <= U_WAIT;
            end
          end
        end
        U_WAIT: begin
          if (reg_rd_valid) begin
            rd_hold <= reg_rd_data;
            ack_tog <= ~ack_tog;
            st      <= U_IDLE;
          end
        end
        default: st <= U_IDLE;
      endcase
    end
  end

  a_r2_wr_single: assert property (@(posedge uclk) disable iff (!urst_n)
    reg_wr_en |=> !reg_wr_en);
  a_r3_rd_single: assert property (@(posedge uclk) disable iff (!urst_n)
    reg_rd_req |=> !reg_rd_req);
  a_r3_addr_hold: assert property (@(posedge uclk) disable iff (!urst_n)
    rd_pending && !reg_rd_valid |=> $stable(reg_addr));
  a_r6_no_overlap: assert property (@(posedge uclk) disable iff (!urst_n)
    rd_pending && !reg_rd_req |-> !reg_wr_en);
  a_r12_ack_only_pending: assert property (@(posedge uclk) disable iff (!urst_n)
    !rd_pending && !req_edge |=> $stable(ack_tog));
endmodule

// File: rtl/axil_reg_bridge.sv
module axil_reg_bridge
  import axil_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic              uclk,
  input  logic              urst_n,
  output logic [ADDR_W-3:0] reg_addr,
  output logic              reg_wr_en,
  output logic [31:0]       reg_wr_data,
  output logic [3:0]        reg_wr_be,
  output logic              reg_rd_req,
  input  logic [31:0]       reg_rd_data,
  input  logic              reg_rd_valid
);
  localparam int RW = ADDR_W - 2;

  logic              xfer_tog, xfer_wr, ack_tog;
  logic [RW-1:0]     xfer_addr;
  logic [DATA_W-1:0] xfer_wdata, rd_hold;
  logic [STRB_W-1:0] xfer_be;

  axil_front #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .aclk(aclk), .aresetn(aresetn),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .xfer_tog(xfer_tog), .xfer_wr(xfer_wr), .xfer_addr(xfer_addr),
    .xfer_wdata(xfer_wdata), .xfer_be(xfer_be),
    .ack_tog_async(ack_tog), .rd_hold_async(rd_hold)
  );

  reg_back #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_back (
    .uclk(uclk), .urst_n(urst_n),
    .xfer_tog_async(xfer_tog), .xfer_wr(xfer_wr), .xfer_addr(xfer_addr),
    .xfer_wdata(xfer_wdata), .xfer_be(xfer_be),
    .ack_tog(ack_tog), .rd_hold(rd_hold),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
    .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid)
  );
endmodule

// File: tb/sim_axil_reg_bridge.sv
module sim_axil_reg_bridge;
  localparam int ADDR_W = 16;
  localparam int RW = ADDR_W - 2;

  logic aclk = 0, uclk = 0, aresetn = 0, urst_n = 0;
  always #10 aclk = ~aclk;   // 50 MHz
  always #7  uclk = ~uclk;

  logic [ADDR_W-1:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_arvalid = 0, s_bready = 0, s_rready = 0;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [RW-1:0] reg_addr;
  logic reg_wr_en, reg_rd_req;
  logic [31:0] reg_wr_data;
  logic [3:0] reg_wr_be;
  logic [31:0] reg_rd_data = '0;
  logic reg_rd_valid = 0;

  axil_reg_bridge #(.ADDR_W(ADDR_W)) u0 (.*);

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // Register-side model
  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  int wr_count = 0, rd_count = 0, seq = 0, wr_seq = 0, rd_seq = 0;
  int overlap = 0, addr_moves = 0, cur_lat = 1, inj_req = 0, inj_done = 0;
  logic [RW-1:0] last_w_addr = '0, rd_addr_q = '0;
  logic [31:0] last_w_data = '0;
  logic [3:0]  last_w_be = '0;

  initial begin
    bit busy = 0;
    int cnt = 0;
    for (int i = 0; i < 16; i++) begin mem[i] = 32'h1000_0000 + i; shadow[i] = mem[i]; end
    forever begin
      @(negedge uclk);
      reg_rd_valid = 0;
      if (reg_wr_en) begin
        wr_count++; seq++; wr_seq = seq;
        last_w_addr = reg_addr; last_w_data = reg_wr_data; last_w_be = reg_wr_be;
        mem[reg_addr[3:0]] = merge(mem[reg_addr[3:0]], reg_wr_data, reg_wr_be);
      end
      if (busy) begin
        if (reg_addr != rd_addr_q) addr_moves++;
        if (reg_wr_en || reg_rd_req) overlap++;
        if (cnt <= 1) begin
          reg_rd_valid = 1; reg_rd_data = mem[rd_addr_q[3:0]]; busy = 0;
        end else cnt--;
      end else if (reg_rd_req) begin
        rd_count++; seq++; rd_seq = seq; rd_addr_q = reg_addr; busy = 1; cnt = cur_lat;
      end else if (inj_req != inj_done) begin
        reg_rd_valid = 1; reg_rd_data = 32'hBAD0_BAD0; inj_done++;
      end
    end
  end

  // AXI master tasks
  task automatic send_aw(input logic [ADDR_W-1:0] a);
    bit rdy;
    @(negedge aclk); s_awaddr = a; s_awvalid = 1;
    do begin rdy = s_awready; @(negedge aclk); end while (!rdy);
    s_awvalid = 0;
  endtask
  task automatic send_w(input logic [31:0] d, input logic [3:0] be);
    bit rdy;
    @(negedge aclk); s_wdata = d; s_wstrb = be; s_wvalid = 1;
    do begin rdy = s_wready; @(negedge aclk); end while (!rdy);
    s_wvalid = 0;
  endtask
  task automatic send_ar(input logic [ADDR_W-1:0] a);
    bit rdy;
    @(negedge aclk); s_araddr = a; s_arvalid = 1;
    do begin rdy = s_arready; @(negedge aclk); end while (!rdy);
    s_arvalid = 0;
  endtask
  task automatic get_b(input int hold, output logic [1:0] resp, output int drops);
    drops = 0;
    while (!s_bvalid) @(negedge aclk);
    for (int i = 0; i < hold; i++) begin @(negedge aclk); if (!s_bvalid) drops++; end
    resp = s_bresp; s_bready = 1; @(negedge aclk); s_bready = 0;
  endtask
  task automatic get_r(input int hold, output logic [31:0] data, output logic [1:0] resp, output int drops);
    drops = 0;
    while (!s_rvalid) @(negedge aclk);
    data = s_rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge aclk); if (!s_rvalid || s_rdata != data) drops++;
    end
    resp = s_rresp; s_rready = 1; @(negedge aclk); s_rready = 0;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [1:0] resp; int drops; int n0;
    n0 = wr_count;
    send_aw(a); send_w(d, be);
    get_b(0, resp, drops);
    shadow[a[5:2]] = merge(shadow[a[5:2]], d, be);
    check(wr_count == n0 + 1, "R2 single write pulse", wr_count, n0 + 1);
    check(last_w_addr == RW'(a >> 2), "R2 write word address", last_w_addr, a >> 2);
    check(last_w_data == d, "R2 write data", last_w_data, d);
    check(last_w_be == be, "R9 byte enable", last_w_be, be);
    check(resp == 2'b00, "R5 bresp okay", resp, 0);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input int lat);
    logic [31:0] d; logic [1:0] resp; int drops; int n0;
    n0 = rd_count; cur_lat = lat;
    send_ar(a);
    get_r(0, d, resp, drops);
    check(rd_count == n0 + 1, "R3 single read request", rd_count, n0 + 1);
    check(rd_addr_q == RW'(a >> 2), "R3 read word address", rd_addr_q, a >> 2);
    check(d == shadow[a[5:2]], "R4 read data", d, shadow[a[5:2]]);
    check(resp == 2'b00, "R4 rresp okay", resp, 0);
  endtask

  // {wr, addr[15:0], data[31:0], be[3:0], lat[3:0]}
  localparam logic [56:0] VEC [8] = '{
    {1'b1, 16'h0010, 32'hDEAD_BEEF, 4'b1111, 4'd0},
    {1'b0, 16'h0010, 32'h0,         4'b0000, 4'd1},
    {1'b1, 16'h0010, 32'h1122_3344, 4'b0101, 4'd0},
    {1'b0, 16'h0010, 32'h0,         4'b0000, 4'd7},
    {1'b1, 16'h7FFC, 32'hA5A5_5A5A, 4'b1000, 4'd0},
    {1'b0, 16'h7FFC, 32'h0,         4'b0000, 4'd3},
    {1'b1, 16'h0004, 32'h0,         4'b0000, 4'd0},
    {1'b0, 16'h0004, 32'h0,         4'b0000, 4'd2}
  };

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] resp; logic [31:0] d; int drops; int n0;
    repeat (4) @(negedge aclk);
    aresetn = 1; urst_n = 1;
    @(negedge aclk);
    // R11 reset state
    check(s_awready && s_wready && s_arready, "R11 readies high", {s_awready, s_wready, s_arready}, 3'b111);
    check(!s_bvalid && !s_rvalid, "R11 valids low", {s_bvalid, s_rvalid}, 0);
    check(!reg_wr_en && !reg_rd_req, "R11 register strobes low", {reg_wr_en, reg_rd_req}, 0);

    // Vector table: R2, R3, R4, R5, R9
    foreach (VEC[i]) begin
      if (VEC[i][56]) do_write(VEC[i][55:40], VEC[i][39:8], VEC[i][7:4]);
      else            do_read(VEC[i][55:40], int'(VEC[i][3:0]));
    end

    // R10 and R1: address alone does nothing, W slot stays open
    n0 = wr_count;
    send_aw(16'h0020);
    repeat (40) @(negedge aclk);
    check(wr_count == n0, "R10 no write without data", wr_count, n0);
    check(!s_bvalid, "R10 no response without data", s_bvalid, 0);
    check(!s_awready && s_wready, "R1 aw slot full, w open", {s_awready, s_wready}, 2'b01);
    send_w(32'hCAFE_0001, 4'b1111);
    get_b(0, resp, drops);
    shadow[8] = merge(shadow[8], 32'hCAFE_0001, 4'hF);
    check(wr_count == n0 + 1 && last_w_addr == RW'(16'h0020 >> 2), "R10 write after data", last_w_addr, 16'h0020 >> 2);

    // R7: write and read arriving together, write goes first
    @(negedge aclk);
    s_awaddr = 16'h0024; s_wdata = 32'h7777_0000; s_wstrb = 4'hF; s_araddr = 16'h0024;
    s_awvalid = 1; s_wvalid = 1; s_arvalid = 1; cur_lat = 2;
    @(negedge aclk);
    s_awvalid = 0; s_wvalid = 0; s_arvalid = 0;
    get_b(0, resp, drops);
    get_r(0, d, resp, drops);
    shadow[9] = merge(shadow[9], 32'h7777_0000, 4'hF);
    check(wr_seq < rd_seq, "R7 write issued before read", wr_seq, rd_seq);
    check(d == 32'h7777_0000, "R7 read sees prior write", d, 32'h7777_0000);

    // R6 and R3: long read pending, write waits; address held
    cur_lat = 15;
    send_ar(16'h0010);
    send_aw(16'h0028); send_w(32'h0BAD_F00D, 4'hF);
    get_r(0, d, resp, drops);
    check(d == shadow[4], "R4 long-latency read data", d, shadow[4]);
    get_b(0, resp, drops);
    shadow[10] = merge(shadow[10], 32'h0BAD_F00D, 4'hF);
    check(rd_seq < wr_seq, "R6 write held behind pending read", rd_seq, wr_seq);
    check(overlap == 0, "R6 no access overlap", overlap, 0);
    check(addr_moves == 0, "R3 address stable while pending", addr_moves, 0);

    // R8: responses held while ready is low
    send_aw(16'h002C); send_w(32'h1357_9BDF, 4'hF);
    get_b(10, resp, drops);
    shadow[11] = 32'h1357_9BDF;
    check(drops == 0, "R8 bvalid held", drops, 0);
    cur_lat = 1;
    send_ar(16'h002C);
    get_r(10, d, resp, drops);
    check(drops == 0, "R8 rvalid and rdata held", drops, 0);
    check(d == 32'h1357_9BDF, "R8 held read data", d, 32'h1357_9BDF);

    // R12: stray read-valid ignored
    inj_req++;
    repeat (30) @(negedge aclk);
    check(inj_done == inj_req, "R12 stray valid delivered", inj_done, inj_req);
    check(!s_rvalid && !s_bvalid, "R12 no response from stray valid", {s_rvalid, s_bvalid}, 0);
    do_read(16'h0024, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule